// File: doc/BRIEF.md
# DRAM Refresh Scheduler With Postponement

This block sits in a memory controller and decides when refresh commands go out. A free-running interval timer counts clock cycles. Its period is the average gap that lets every row be covered once inside the 64 ms retention window. With 8192 rows, that gap is 7.8125 µs, which the timer turns into a cycle count from a clock-frequency parameter.

Each expiry of the timer adds one refresh credit. Owed refreshes therefore accumulate while the controller is busy with normal traffic. They are paid back when the request port goes quiet. Once the backlog reaches its ceiling, the block raises an urgent flag. It then puts the refresh ahead of any pending read or write.

The block also models the memory device's own refresh row counter. That counter steps by one on every refresh command without any address being sent. While a refresh is in progress, normal traffic is held off for a fixed recovery time.

Top module: `dram_refresh_sched`

## Requirements
- R1: The interval timer grants one credit every floor(CLK_MHZ × 78125 / 10000) cycles after reset, the first one on that many rising edges after reset is released.
- R2: The credit count never exceeds 8; a timer expiry at 8 with no refresh in that cycle is discarded.
- R3: When the credit count equals 8, `ref_urgent` is high, `req_grant` is low, and a refresh is issued in that cycle even though `req_valid` is high, provided no refresh recovery is in progress.
- R4: With 1 to 7 credits and no recovery in progress, a refresh is issued only in a cycle where `req_valid` is low; while `req_valid` is high, the request is granted instead.
- R5: Each issued refresh lowers the credit count by one, plus one if a timer expiry lands in the same cycle.
- R6: For RFC_CYC cycles after a refresh command, neither a grant nor another refresh is given.
- R7: The device row counter (13 bits by default) starts at 0, increments by one on each refresh command and wraps from 8191 to 0.
- R8: Synchronous reset clears the credit count and the row counter, restarts the interval timer and cancels any recovery.
- R9: `req_grant` and `ref_cmd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Normal read/write traffic wants the memory this cycle |
| req_grant | output | 1 | Normal traffic may proceed this cycle |
| ref_cmd | output | 1 | Refresh command issued this cycle |
| ref_urgent | output | 1 | Refresh backlog at its ceiling; traffic is blocked |
| ref_credits | output | CW (4) | Number of refreshes currently owed |
| dev_row | output | ROW_BITS (13) | Device-side row counter value |

## Verification
The assertions take `req_valid` to be a clean, synchronous level that is sampled on the rising edge. They make no assumption about how long it stays high, so any pattern of traffic is legal, including traffic that never goes idle. The stimulus changes `req_valid` shortly after a rising edge and reads results at the falling edge, so each decision sees one settled request value. The bench sets the clock-frequency parameter to 1 so that the interval is 7 cycles. This lets saturation, draining and a full row wrap all happen within a short run.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
    // Average refresh gap is 7812.5 ns; cycles = MHz * 7812.5 / 1000
    function automatic int refi_cycles(input int clk_mhz);
        int c;
        c = (clk_mhz * 78125) / 10000;
        return (c < 2) ? 2 : c;
    endfunction

    typedef enum logic [1:0] {
        ARB_IDLE    = 2'd0,
        ARB_GRANT   = 2'd1,
        ARB_REFRESH = 2'd2,
        ARB_HOLD    = 2'd3
    } arb_e;

    typedef struct packed {
        logic grant;
        logic refresh;
        logic urgent;
    } arb_out_t;
endpackage

// File: rtl/refi_timer.sv
module refi_timer #(
    parameter int IVL = 781,
    localparam int TW = $clog2(IVL + 1)
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    logic [TW-1:0] cnt_q;

    assign tick_o = (cnt_q == TW'(IVL - 1));

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
endmodule

// File: rtl/refresh_credit.sv
module refresh_credit
    import rfsh_pkg::*;
#(
    parameter int MAX_CRED = 8,
    parameter int RFC_CYC  = 4,
    localparam int CW = $clog2(MAX_CRED + 1),
    localparam int BW = $clog2(RFC_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          req_valid_i,
    output arb_out_t      arb_o,
    output logic [CW-1:0] credits_o
);
    logic [CW-1:0] cred_q;
    logic [BW-1:0] busy_q;
    logic [CW:0]   cred_sum;
    arb_e          dec;
    logic          urgent;

    assign urgent = (cred_q == CW'(MAX_CRED));

    always_comb begin
        if (busy_q != '0)
            dec = ARB_HOLD;
        else if ((cred_q != '0) && (urgent || !req_valid_i))
            dec = ARB_REFRESH;
        else if (req_valid_i)
            dec = ARB_GRANT;
        else
            dec = ARB_IDLE;
    end

    always_comb begin
        arb_o.grant   = (dec == ARB_GRANT);
        arb_o.refresh = (dec == ARB_REFRESH);
        arb_o.urgent  = urgent;
    end

    assign cred_sum = {1'b0, cred_q} + (CW+1)'(tick_i) - (CW+1)'(arb_o.refresh);

    always_ff @(posedge clk) begin
        if (rst) begin
            cred_q <= '0;
            busy_q <= '0;
        end else begin
            cred_q <= (cred_sum > (CW+1)'(MAX_CRED)) ? CW'(MAX_CRED) : cred_sum[CW-1:0];
            if (arb_o.refresh)       busy_q <= BW'(RFC_CYC);
            else if (busy_q != '0)   busy_q <= busy_q - 1'b1;
        end
    end

    assign credits_o = cred_q;

    // R3
    urgent_block_chk: assert property (@(posedge clk) disable iff (rst)
        arb_o.urgent |-> !arb_o.grant);
    // R9
    grant_ref_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(arb_o.grant && arb_o.refresh));
    // R6
    recovery_hold_chk: assert property (@(posedge clk) disable iff (rst)
        arb_o.refresh |=> (!arb_o.grant && !arb_o.refresh));
    // R5
    credit_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (arb_o.refresh && !tick_i) |=> (credits_o == $past(credits_o) - 1'b1));
    // R2
    credit_cap_chk: assert property (@(posedge clk) disable iff (rst)
        credits_o <= CW'(MAX_CRED));
endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr #(
    parameter int ROW_BITS = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ref_i,
    output logic [ROW_BITS-1:0] row_o
);
    always_ff @(posedge clk) begin
        if (rst)        row_o <= '0;
        else if (ref_i) row_o <= row_o + 1'b1;
    end

    // R7
    row_step_chk: assert property (@(posedge clk) disable iff (rst)
        ref_i |=> (row_o == $past(row_o) + 1'b1));
    // R7
    row_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ref_i |=> $stable(row_o));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import rfsh_pkg::*;
#(
    parameter int CLK_MHZ  = 100,
    parameter int MAX_CRED = 8,
    parameter int RFC_CYC  = 4,
    parameter int ROW_BITS = 13,
    localparam int CW  = $clog2(MAX_CRED + 1),
    localparam int IVL = refi_cycles(CLK_MHZ)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_grant,
    output logic                ref_cmd,
    output logic                ref_urgent,
    output logic [CW-1:0]       ref_credits,
    output logic [ROW_BITS-1:0] dev_row
);
    logic     tick;
    arb_out_t arb;

    refi_timer #(.IVL(IVL)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    refresh_credit #(.MAX_CRED(MAX_CRED), .RFC_CYC(RFC_CYC)) u_credit (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick),
        .req_valid_i (req_valid),
        .arb_o       (arb),
        .credits_o   (ref_credits)
    );

    refresh_row_ctr #(.ROW_BITS(ROW_BITS)) u_row (
        .clk   (clk),
        .rst   (rst),
        .ref_i (arb.refresh),
        .row_o (dev_row)
    );

    assign req_grant  = arb.grant;
    assign ref_cmd    = arb.refresh;
    assign ref_urgent = arb.urgent;

    // R3
    urgent_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_urgent && !$past(ref_cmd)) |-> ref_cmd);
endmodule

// File: tb/tb_dram_refresh_sched.sv
module tb_dram_refresh_sched;
    localparam int ROWS = 8192;
    localparam int IVL  = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_grant, ref_cmd, ref_urgent;
    logic [3:0]  ref_credits;
    logic [12:0] dev_row;

    int checks = 0;
    int fails  = 0;
    int nref   = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dram_refresh_sched #(.CLK_MHZ(1), .MAX_CRED(8), .RFC_CYC(4), .ROW_BITS(13)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .req_grant(req_grant), .ref_cmd(ref_cmd), .ref_urgent(ref_urgent),
        .ref_credits(ref_credits), .dev_row(dev_row)
    );

    always @(negedge clk) if (!rst && ref_cmd) nref++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // advance n rising edges, set request after the edge, end at the following falling edge
    task automatic step(input int n, input logic req);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            req_valid = req;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(posedge clk); #2;
        rst = 1'b1; req_valid = 1'b0;
        @(posedge clk); @(posedge clk); #2;
        rst = 1'b0;
        @(negedge clk);
        nref = 0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check(ref_credits == 0, "R8 credits", ref_credits, 0);
        check(dev_row == 0, "R8 row", dev_row, 0);
        check(!ref_urgent && !ref_cmd && !req_grant, "R8 outputs", {ref_urgent, ref_cmd, req_grant}, 0);
    endtask

    task automatic t_idle_first();
        do_reset();
        step(IVL - 1, 1'b0);
        check(ref_credits == 0 && !ref_cmd, "R1 before interval", ref_credits, 0);
        step(1, 1'b0);
        check(ref_credits == 1, "R1 first credit", ref_credits, 1);
        check(ref_cmd == 1, "R4 idle refresh", ref_cmd, 1);
        step(1, 1'b0);
        check(ref_credits == 0, "R5 decrement", ref_credits, 0);
        check(dev_row == 1, "R7 row step", dev_row, 1);
    endtask

    task automatic t_busy_urgent();
        do_reset();
        step(1, 1'b1);
        step(54, 1'b1);
        check(ref_credits == 7, "R1 seven credits", ref_credits, 7);
        check(req_grant && !ref_cmd, "R4 postponed", {req_grant, ref_cmd}, 2);
        step(1, 1'b1);
        check(ref_credits == 8 && ref_urgent, "R2 ceiling", ref_credits, 8);
        check(ref_cmd && !req_grant, "R3 forced refresh", {ref_cmd, req_grant}, 2);
        step(1, 1'b1);
        check(ref_credits == 7, "R5 after forced", ref_credits, 7);
        check(dev_row == 1, "R7 row after forced", dev_row, 1);
        for (int i = 0; i < 3; i++) begin
            check(!req_grant && !ref_cmd, "R6 recovery", {req_grant, ref_cmd}, 0);
            step(1, 1'b1);
        end
        check(!req_grant && !ref_cmd, "R6 recovery last", {req_grant, ref_cmd}, 0);
        step(1, 1'b1);
        check(req_grant && !ref_cmd, "R6 recovery over", {req_grant, ref_cmd}, 2);
        for (int i = 0; i < 200; i++) begin
            if (ref_credits > 8 || (req_grant && ref_cmd)) begin
                check(1'b0, "R2 R9 under load", ref_credits, 8);
                break;
            end
            step(1, 1'b1);
        end
        check(1'b1, "R9 under load", 0, 0);
    endtask

    task automatic t_drain();
        int k;
        step(1, 1'b0);
        k = 0;
        while (ref_credits != 0 && k < 200) begin
            step(1, 1'b0);
            k++;
        end
        check(ref_credits == 0, "R4 drained", ref_credits, 0);
        check(dev_row == 13'(nref), "R7 row count", dev_row, nref);
    endtask

    task automatic t_wrap();
        int k;
        k = 0;
        while (dev_row != 13'(ROWS - 1) && k < 70000) begin
            step(1, 1'b0);
            k++;
        end
        check(dev_row == 13'(ROWS - 1), "R7 reach top", dev_row, ROWS - 1);
        k = 0;
        while (!ref_cmd && k < 50) begin
            step(1, 1'b0);
            k++;
        end
        step(1, 1'b0);
        check(dev_row == 0, "R7 wrap", dev_row, 0);
        check(dev_row == 13'(nref % ROWS), "R7 total", dev_row, nref % ROWS);
    endtask

    task automatic t_mid_reset();
        step(20, 1'b1);
        do_reset();
        check(ref_credits == 0 && dev_row == 0, "R8 mid-run", {ref_credits, dev_row}, 0);
        step(IVL, 1'b1);
        check(ref_credits == 1 && req_grant, "R1 restart", ref_credits, 1);
    endtask

    initial begin
        t_reset_state();
        t_idle_first();
        t_busy_urgent();
        t_drain();
        t_wrap();
        t_mid_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule